// File: doc/BRIEF.md
# Interleaved I/Q Receive Capture for a Double-Data-Rate ADC Bus

This block sits directly behind the pins of a 14-bit ADC that shares one data bus between two channels. The converter sends a source-synchronous clock together with the bus. The in-phase word is valid at the rising edge of that clock, and the quadrature word is valid at the falling edge. Both words are two's complement. An over-range level travels alongside the data and can change at either edge.

The block samples the bus on both edges. It holds the falling-edge word until the next rising edge, so the two halves of one clock period reach the ADC clock domain as a single aligned I/Q pair. A combined over-range flag and a valid strobe go out with each pair. The capture clock (nominally 125 MHz) is assumed to be deskewed before it reaches the block. Rate conversion and the hand-off into the system clock domain are handled downstream.

Top module: `adc_iq_deint`

## Requirements
- R1: A word present on `d_i` at rising edge k appears unchanged on `i_o` from just after rising edge k+1 until rising edge k+2.
- R2: The word present on `d_i` at the falling edge between rising edges k and k+1 appears on `q_o` in the same output cycle as the I word of edge k.
- R3: Samples pass bit-exact with no sign handling. The extreme two's-complement codes 14'h2000 (most negative) and 14'h1FFF (most positive) come out unchanged on both channels.
- R4: `ovr_o` is high in an output cycle exactly when `ovr_i` was high at the rising edge, or at the following falling edge, of the clock period that produced that pair.
- R5: After reset is released, `valid_o` stays low through the first rising edge. It rises after the second rising edge and then stays high on every cycle until the next reset.
- R6: While `rst_ni` is low, `i_o`, `q_o`, `ovr_o` and `valid_o` are all zero, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source-synchronous ADC clock, deskewed |
| rst_ni | input | 1 | Active-low asynchronous reset |
| d_i | input | DATA_W (14) | Shared data bus: I at the rising edge, Q at the falling edge |
| ovr_i | input | 1 | Over-range level from the converter |
| i_o | output | DATA_W (14) | Aligned in-phase sample |
| q_o | output | DATA_W (14) | Aligned quadrature sample |
| ovr_o | output | 1 | Over-range seen on either edge of the pair's period |
| valid_o | output | 1 | Pipeline filled; pair outputs carry samples |

## Verification
The bound checker checks several rules on every rising edge. It checks the two-edge latency of the I path against the input bus, the alignment of `q_o` with the falling-edge capture register, and that an over-range at the I edge reaches `ovr_o`. It also checks that `valid_o` never drops once it is high, and that all outputs are clear while reset is held. A posedge-sampled property cannot see the bus at the falling edge itself. For that reason, the pairing of each falling-edge Q word with the preceding I word is shown only by the bench scenarios. The same applies to an over-range raised only at the falling edge, to the exact edge on which `valid_o` first rises, and to the pass-through of the extreme codes.

// File: rtl/adc_rx_pkg.sv
`timescale 1ns/1ps
package adc_rx_pkg;
  localparam int unsigned ADC_W       = 14;  // converter resolution
  localparam int unsigned FILL_STAGES = 2;   // rising edges until first aligned pair
endpackage

// File: rtl/ddr_capture_cell.sv
`timescale 1ns/1ps
// One rising and one falling register per pin.
module ddr_capture_cell #(
  parameter int unsigned W = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  for (genvar b = 0; b < W; b++) begin : g_pin
    logic rise_q, fall_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rise_q <= 1'b0;
      else         rise_q <= pin_i[b];
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fall_q <= 1'b0;
      else         fall_q <= pin_i[b];
    end

    assign rise_o[b] = rise_q;
    assign fall_o[b] = fall_q;
  end
endmodule

// File: rtl/same_edge_align.sv
`timescale 1ns/1ps
// Re-registers both edge words on the next rising edge.
module same_edge_align #(
  parameter int unsigned W = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  output logic [W-1:0] first_o,
  output logic [W-1:0] second_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_o  <= '0;
      second_o <= '0;
    end else begin
      first_o  <= rise_i;
      second_o <= fall_i;
    end
  end
endmodule

// File: rtl/valid_fill.sv
`timescale 1ns/1ps
module valid_fill #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic valid_o
);
  logic [STAGES-1:0] fill_q;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fill_q <= '0;
      else         fill_q <= 1'b1;
    end
  end else begin : g_shift
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fill_q <= '0;
      else         fill_q <= {fill_q[STAGES-2:0], 1'b1};
    end
  end

  assign valid_o = fill_q[STAGES-1];
endmodule

// File: rtl/adc_iq_deint.sv
`timescale 1ns/1ps
module adc_iq_deint #(
  parameter int unsigned DATA_W = adc_rx_pkg::ADC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] d_i,
  input  logic              ovr_i,
  output logic [DATA_W-1:0] i_o,
  output logic [DATA_W-1:0] q_o,
  output logic              ovr_o,
  output logic              valid_o
);
  localparam int unsigned BUS_W = DATA_W + 1;  // data plus over-range bit
  localparam int unsigned OVR_B = DATA_W;

  logic [BUS_W-1:0] rise_word, fall_word;
  logic [BUS_W-1:0] pair_first, pair_second;

  ddr_capture_cell #(.W(BUS_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  ({ovr_i, d_i}),
    .rise_o (rise_word),
    .fall_o (fall_word)
  );

  same_edge_align #(.W(BUS_W)) u_align (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (rise_word),
    .fall_i   (fall_word),
    .first_o  (pair_first),
    .second_o (pair_second)
  );

  valid_fill #(.STAGES(adc_rx_pkg::FILL_STAGES)) u_fill (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_o (valid_o)
  );

  assign i_o   = pair_first[DATA_W-1:0];
  assign q_o   = pair_second[DATA_W-1:0];
  assign ovr_o = pair_first[OVR_B] | pair_second[OVR_B];
endmodule

// File: rtl/adc_iq_deint_chk.sv
`timescale 1ns/1ps
module adc_iq_deint_chk #(
  parameter int unsigned W = 14
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] d_i,
  input logic         ovr_i,
  input logic [W-1:0] i_o,
  input logic [W-1:0] q_o,
  input logic         ovr_o,
  input logic         valid_o,
  input logic [W:0]   fall_w
);
  a_r1_i_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> i_o == $past(d_i, 2));

  a_r2_q_pairs_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> q_o == $past(fall_w[W-1:0]));

  a_r4_ovr_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(ovr_i, 2)) |-> ovr_o);

  a_r5_valid_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);

  a_r5_valid_not_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(rst_ni));

  a_r6_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && !ovr_o && i_o == '0 && q_o == '0));
endmodule

bind adc_iq_deint adc_iq_deint_chk #(.W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .d_i     (d_i),
  .ovr_i   (ovr_i),
  .i_o     (i_o),
  .q_o     (q_o),
  .ovr_o   (ovr_o),
  .valid_o (valid_o),
  .fall_w  (fall_word)
);

// File: tb/sim_adc_iq_deint.sv
`timescale 1ns/1ps
module sim_adc_iq_deint;
  localparam int W = 14;

  logic         clk = 1'b0;
  logic         rst_ni;
  logic [W-1:0] d;
  logic         ovr;
  logic [W-1:0] i_o, q_o;
  logic         ovr_o, valid_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [W-1:0] p_i, p_q;
  logic         p_ovr;
  bit           have_prev;
  string        p_tag;

  always #2 clk = ~clk;

  adc_iq_deint u0 (
    .clk_i(clk), .rst_ni(rst_ni), .d_i(d), .ovr_i(ovr),
    .i_o(i_o), .q_o(q_o), .ovr_o(ovr_o), .valid_o(valid_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Drive I before a rising edge and Q after it; check the previous pair.
  task automatic step(input logic [W-1:0] iv, input logic [W-1:0] qv,
                      input logic oi, input logic oq, input string tag);
    @(negedge clk); #1;
    d = iv; ovr = oi;
    @(posedge clk); #1;
    if (have_prev) begin
      chk(i_o == p_i, {p_tag, " R1 i"}, i_o, p_i);
      chk(q_o == p_q, {p_tag, " R2 q"}, q_o, p_q);
      chk(ovr_o == p_ovr, {p_tag, " R4 ovr"}, ovr_o, p_ovr);
      chk(valid_o == 1'b1, "R5 valid held", valid_o, 1);
    end
    d = qv; ovr = oq;
    p_i = iv; p_q = qv; p_ovr = oi | oq; p_tag = tag; have_prev = 1;
  endtask

  task automatic t_reset;
    rst_ni = 1'b1; d = '0; ovr = 1'b0; have_prev = 0;
    #1 rst_ni = 1'b0;
    #10;
    chk(valid_o == 0 && i_o == 0 && q_o == 0 && ovr_o == 0, "R6 reset state",
        {valid_o, ovr_o, i_o}, 0);
    #2 rst_ni = 1'b1;            // released at t=13, edges at 14 and 18
    @(posedge clk); #1;
    chk(valid_o == 0, "R5 valid low after first edge", valid_o, 0);
    @(posedge clk); #1;
    chk(valid_o == 1, "R5 valid high after second edge", valid_o, 1);
  endtask

  task automatic t_ramp;
    for (int n = 0; n < 20; n++)
      step(W'(n * 37 + 5), W'(16383 - n * 53), 1'b0, 1'b0, "ramp");
  endtask

  task automatic t_alternate;
    for (int n = 0; n < 8; n++)
      step((n % 2) ? 14'h2AAA : 14'h1555, (n % 2) ? 14'h0F0F : 14'h30F0,
           1'b0, 1'b0, "alternate");
  endtask

  task automatic t_extremes;
    step(14'h2000, 14'h1FFF, 1'b0, 1'b0, "R3 extremes");
    step(14'h1FFF, 14'h2000, 1'b0, 1'b0, "R3 extremes");
    step(14'h3FFF, 14'h0000, 1'b0, 1'b0, "R3 extremes");
    step(14'h0000, 14'h3FFF, 1'b0, 1'b0, "R3 extremes");
  endtask

  task automatic t_ovr;
    step(14'h0100, 14'h0200, 1'b1, 1'b0, "ovr rise only");
    step(14'h0101, 14'h0201, 1'b0, 1'b1, "ovr fall only");
    step(14'h0102, 14'h0202, 1'b0, 1'b0, "ovr none");
    step(14'h0103, 14'h0203, 1'b1, 1'b1, "ovr both");
    step(14'h0104, 14'h0204, 1'b0, 1'b0, "ovr none");
  endtask

  task automatic t_mid_reset;
    step(14'h1234, 14'h0567, 1'b1, 1'b1, "pre reset");
    step(14'h0ABC, 14'h0DEF, 1'b1, 1'b1, "pre reset");
    @(negedge clk); #1;
    rst_ni = 1'b0;
    #1;
    chk(valid_o == 0 && i_o == 0 && q_o == 0 && ovr_o == 0, "R6 async clear",
        {valid_o, ovr_o, i_o}, 0);
    have_prev = 0;
    @(posedge clk); #3;
    rst_ni = 1'b1;               // between negedge and next rising edge
    @(posedge clk); #1;
    chk(valid_o == 0, "R5 refill first edge", valid_o, 0);
    @(posedge clk); #1;
    chk(valid_o == 1, "R5 refill second edge", valid_o, 1);
    step(14'h0777, 14'h0888, 1'b0, 1'b0, "post reset");
    step(14'h0999, 14'h0AAA, 1'b0, 1'b0, "post reset");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_ramp();
    t_alternate();
    t_extremes();
    t_ovr();
    t_mid_reset();
    step('0, '0, 1'b0, 1'b0, "flush");
    finish_run();
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog expired t=%0t", $time);
    finish_run();
  end
endmodule